// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the slave side of a four-wire serial bus (clock idle low or idle high, data captured on the rising clock edge, MSB first) that fronts a byte-wide memory array. It decodes one-byte commands that set and clear a write-enable latch and a general-purpose flag bit, read and write a status register, and read and write the array. The array itself sits outside the block, behind a simple address/data port with a write strobe and a combinational read-data input.

All bus pins are sampled by the system clock through a short synchronizer, so the serial clock must run several times slower than `clk`. Reads stream sequential bytes from any start address and wrap from the top of the array to address zero. Writes gather up to one page of data into a local buffer. The buffered page is committed to the array only when chip select rises cleanly on a byte boundary. After that, a self-timed busy period runs for a parameter number of clocks, and the busy bit in the status register shows it. Writes are guarded in three ways: by the write-enable latch, by a two-bit block-lock field that protects the top quarter, the top half or the whole array, and by a write-protect pin that locks the status register once a status bit arms it.

Top module: `spi_mem_engine`

## Requirements
- R1: After reset the status byte is 0x00 and SO is not driven. A command is accepted only after chip select has been seen high and then low; a select that is already low when reset ends is ignored until it goes high.
- R2: `so_oe` is 1 only while the block shifts out status or array data, and goes to 0 once `cs_n` is high. Output bits change after the falling serial-clock edge, MSB first.
- R3: Opcode 0x06 sets the write-enable latch (status bit 1). Opcode 0x00 sets the flag (status bit 6). Opcode 0x04 clears both.
- R4: Opcode 0x05 returns the status byte as {bit7 lock-enable, bit6 flag, bits5:4 timer select, bits3:2 block-lock, bit1 write-enable, bit0 busy}, and repeats it for as long as the serial clock runs.
- R5: Opcode 0x03 followed by a 16-bit address (unused upper bits zero) streams bytes from consecutive addresses, wrapping from the highest address to 0.
- R6: Opcode 0x02 and opcode 0x01 are ignored when the write-enable latch is clear. No array or status change follows.
- R7: A write commits only if chip select rises right after bit 0 of a data byte and at least one data byte was sent. Otherwise nothing is written, no busy period starts and the write-enable latch keeps its value.
- R8: Write data that runs past the end of a 32-byte page wraps to the first byte of the same page.
- R9: Block-lock 00 protects nothing, 01 protects the top quarter, 10 the top half and 11 the whole array. Protected bytes keep their contents on a write.
- R10: A status write stores data bits 7:2 and ignores bits 1:0. With lock-enable set and `wp_n` low, a status write is refused: no busy period, and the write-enable latch stays set. A status write that was accepted completes even if `wp_n` falls afterwards.
- R11: After a commit the busy bit reads 1 for WRITE_TICKS clocks. While it is 1, only opcode 0x05 has any effect. The write-enable latch clears when the busy period ends.
- R12: Bits that follow a complete one-byte command within the same select are ignored, so a write sent straight after 0x06 without raising chip select does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Status write-protect pin, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_addr | output | ADDR_W | Array address (read pointer, or commit address while busy) |
| mem_wdata | output | 8 | Array write data |
| mem_we | output | 1 | Array write strobe |
| mem_rdata | input | 8 | Array read data for `mem_addr` |

## Verification
A corrupted command state shows on the next status read. A latch or flag that is set wrongly, or a busy bit stuck high or low, appears in the status byte within one command of the fault. A wrong write pointer or page base shows as array bytes landing at the wrong address, and a faulty lock decode shows as a protected byte that changed. The bench sees either of these on the read that follows the busy period, after about a few hundred clocks. Commit faults on the byte boundary are caught at once: an aborted write must leave the busy bit clear on the very next status read.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OP,
        S_ADDR,
        S_RDAT,
        S_RSTAT,
        S_WDAT,
        S_WSTAT,
        S_SKIP
    } spim_state_e;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_SFLAG = 8'h00;
    localparam logic [7:0] OP_CLR   = 8'h04;
    localparam logic [7:0] OP_RSTAT = 8'h05;
    localparam logic [7:0] OP_WSTAT = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    typedef struct packed {
        logic       lock_en;
        logic       flag;
        logic [1:0] tsel;
        logic [1:0] blk;
        logic       wel;
        logic       busy;
    } spim_status_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sel;
        logic cs_up;
        logic din;
        logic wp_n;
    } spim_pins_t;

    // Top two address bits against the block-lock code.
    function automatic logic region_locked(input logic [1:0] blk, input logic [1:0] top);
        case (blk)
            2'b00:   return 1'b0;
            2'b01:   return top == 2'b11;
            2'b10:   return top[1];
            default: return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/spim_sync.sv
module spim_sync
    import spim_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       si,
    input  logic       wp_n,
    output spim_pins_t pins
);
    // order {sck, cs_n, si, wp_n}; chip select resets low so no false arm
    localparam logic [3:0] RST_VAL = 4'b0001;

    logic [3:0] pipe [DEPTH];
    logic       sck_prev;
    logic       cs_prev;
    logic [3:0] cur;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= RST_VAL;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b0;
        end else begin
            pipe[0] <= {sck, cs_n, si, wp_n};
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
            sck_prev <= pipe[DEPTH-1][3];
            cs_prev  <= pipe[DEPTH-1][2];
        end
    end

    assign cur        = pipe[DEPTH-1];
    assign pins.rise  = cur[3] & ~sck_prev;
    assign pins.fall  = ~cur[3] & sck_prev;
    assign pins.sel   = ~cur[2];
    assign pins.cs_up = cur[2] & ~cs_prev;
    assign pins.din   = cur[1];
    assign pins.wp_n  = cur[0];

endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  spim_pins_t        pins,
    input  logic              busy,
    input  logic              done,
    input  logic [7:0]        mem_rdata,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] ptr,
    output spim_status_t      status,
    output logic              page_start,
    output logic              byte_we,
    output logic [PAGE_W-1:0] byte_off,
    output logic [7:0]        byte_data,
    output logic              go,
    output logic              go_arr
);
    spim_state_e st;
    logic [2:0]  bitn;
    logic [7:0]  shreg;
    logic [7:0]  sbyte;
    logic        armed, ahalf, rd_mode, got;
    logic        lock_en, flag, wel;
    logic [1:0]  tsel, blk;
    logic [7:0]  stat_v;
    logic [7:0]  nb;
    logic        last;

    assign nb     = {shreg[6:0], pins.din};
    assign last   = pins.rise && (bitn == 3'd7);
    assign status = '{lock_en: lock_en, flag: flag, tsel: tsel, blk: blk, wel: wel, busy: busy};
    assign stat_v = status;
    assign so_oe  = (st == S_RDAT) || (st == S_RSTAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  bitn <= '0;  shreg <= '0;  sbyte <= '0;
            armed <= 1'b0; ahalf <= 1'b0; rd_mode <= 1'b0; got <= 1'b0;
            lock_en <= 1'b0; flag <= 1'b0; wel <= 1'b0; tsel <= '0; blk <= '0;
            so <= 1'b0; ptr <= '0; page_start <= 1'b0; byte_we <= 1'b0;
            byte_off <= '0; byte_data <= '0; go <= 1'b0; go_arr <= 1'b0;
        end else begin
            page_start <= 1'b0;
            byte_we    <= 1'b0;
            go         <= 1'b0;
            go_arr     <= 1'b0;
            if (done) wel <= 1'b0;
            if (!pins.sel) begin
                armed <= 1'b1;
                st    <= S_IDLE;
                bitn  <= '0;
                ahalf <= 1'b0;
                got   <= 1'b0;
                if (pins.cs_up && bitn == 3'd0 && got) begin
                    if (st == S_WDAT) begin
                        go     <= 1'b1;
                        go_arr <= 1'b1;
                    end else if (st == S_WSTAT && !(lock_en && !pins.wp_n)) begin
                        go <= 1'b1;
                        {lock_en, flag, tsel, blk} <= sbyte[7:2];
                    end
                end
            end else if (st == S_IDLE) begin
                if (armed) st <= S_OP;
            end else begin
                if (pins.rise) begin
                    shreg <= nb;
                    bitn  <= bitn + 3'd1;
                end
                if (pins.fall) begin
                    if (st == S_RDAT)  so <= mem_rdata[~bitn];
                    if (st == S_RSTAT) so <= stat_v[~bitn];
                end
                if (last) begin
                    unique case (st)
                        S_OP: begin
                            if (busy && nb != OP_RSTAT) st <= S_SKIP;
                            else begin
                                case (nb)
                                    OP_WREN:  begin wel <= 1'b1; st <= S_SKIP; end
                                    OP_SFLAG: begin flag <= 1'b1; st <= S_SKIP; end
                                    OP_CLR:   begin wel <= 1'b0; flag <= 1'b0; st <= S_SKIP; end
                                    OP_RSTAT: st <= S_RSTAT;
                                    OP_WSTAT: st <= wel ? S_WSTAT : S_SKIP;
                                    OP_READ:  begin st <= S_ADDR; rd_mode <= 1'b1; end
                                    OP_WRITE: begin st <= wel ? S_ADDR : S_SKIP; rd_mode <= 1'b0; end
                                    default:  st <= S_SKIP;
                                endcase
                            end
                        end
                        S_ADDR: begin
                            ptr   <= ADDR_W'({ptr, nb});
                            ahalf <= 1'b1;
                            if (ahalf) begin
                                st <= rd_mode ? S_RDAT : S_WDAT;
                                page_start <= !rd_mode;
                            end
                        end
                        S_RDAT: ptr <= ptr + 1'b1;
                        S_WDAT: begin
                            byte_we   <= 1'b1;
                            byte_data <= nb;
                            byte_off  <= ptr[PAGE_W-1:0];
                            ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
                            got <= 1'b1;
                        end
                        S_WSTAT: begin
                            if (got) st <= S_SKIP;
                            else begin
                                sbyte <= nb;
                                got   <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/spim_page.sv
module spim_page
    import spim_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int WRITE_TICKS = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [ADDR_W-PAGE_W-1:0] base_in,
    input  logic                     byte_we,
    input  logic [PAGE_W-1:0]        byte_off,
    input  logic [7:0]               byte_data,
    input  logic                     go,
    input  logic                     go_arr,
    input  logic [1:0]               blk,
    output logic                     busy,
    output logic                     done,
    output logic [ADDR_W-1:0]        cm_addr,
    output logic                     cm_we,
    output logic [7:0]               cm_data
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int TW     = $clog2(WRITE_TICKS + 1);
    localparam logic [TW-1:0] PAGE_LIM = TW'(PAGE_BYTES);
    localparam logic [TW-1:0] LAST_T   = TW'(WRITE_TICKS - 1);

    logic [7:0]               pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]    vld;
    logic [ADDR_W-PAGE_W-1:0] base;
    logic                     arr;
    logic [TW-1:0]            tick;
    logic [PAGE_W-1:0]        off;

    always_ff @(posedge clk) begin
        if (byte_we) pbuf[byte_off] <= byte_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld  <= '0;
            base <= '0;
            arr  <= 1'b0;
            tick <= '0;
            busy <= 1'b0;
        end else begin
            if (start) begin
                vld  <= '0;
                base <= base_in;
            end
            if (byte_we) vld[byte_off] <= 1'b1;
            if (go) begin
                busy <= 1'b1;
                tick <= '0;
                arr  <= go_arr;
            end else if (busy) begin
                tick <= tick + 1'b1;
                if (done) busy <= 1'b0;
            end
        end
    end

    assign done    = busy && (tick == LAST_T);
    assign off     = tick[PAGE_W-1:0];
    assign cm_addr = {base, off};
    assign cm_data = pbuf[off];
    assign cm_we   = busy && arr && (tick < PAGE_LIM) && vld[off]
                     && !region_locked(blk, cm_addr[ADDR_W-1 -: 2]);

endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
    import spim_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_BYTES  = 32,
    parameter int WRITE_TICKS = 64,
    parameter int SYNC_DEPTH  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              wp_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata
);
    localparam int PAGE_W = $clog2(PAGE_BYTES);

    spim_pins_t        pins;
    spim_status_t      stat;
    logic              busy, done, page_start, byte_we, go, go_arr;
    logic [PAGE_W-1:0] byte_off;
    logic [7:0]        byte_data;
    logic [ADDR_W-1:0] ptr, cm_addr;

    spim_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n), .pins(pins)
    );

    spim_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
        .clk(clk), .rst(rst), .pins(pins), .busy(busy), .done(done),
        .mem_rdata(mem_rdata), .so(so), .so_oe(so_oe), .ptr(ptr), .status(stat),
        .page_start(page_start), .byte_we(byte_we), .byte_off(byte_off),
        .byte_data(byte_data), .go(go), .go_arr(go_arr)
    );

    spim_page #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_TICKS(WRITE_TICKS)) u_page (
        .clk(clk), .rst(rst), .start(page_start), .base_in(ptr[ADDR_W-1:PAGE_W]),
        .byte_we(byte_we), .byte_off(byte_off), .byte_data(byte_data),
        .go(go), .go_arr(go_arr), .blk(stat.blk), .busy(busy), .done(done),
        .cm_addr(cm_addr), .cm_we(mem_we), .cm_data(mem_wdata)
    );

    assign mem_addr = busy ? cm_addr : ptr;

endmodule

// File: rtl/spi_mem_engine_chk.sv
module spi_mem_engine_chk
    import spim_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              so_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              busy,
    input logic              wel,
    input logic [1:0]        blk
);
    // R2
    oe_off_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> !so_oe);

    // R11
    we_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R9
    we_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !region_locked(blk, mem_addr[ADDR_W-1 -: 2]));

    // R11
    wel_clear_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);

    // R6
    busy_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wel);
endmodule

bind spi_mem_engine spi_mem_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .so_oe(so_oe), .mem_we(mem_we),
    .mem_addr(mem_addr), .busy(busy), .wel(stat.wel), .blk(stat.blk)
);

// File: tb/spi_mem_engine_test.sv
module spi_mem_engine_test;
    localparam int AW = 11;
    localparam int WT = 600;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst, sck, cs_n, si, wp_n;
    logic so, so_oe, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic [7:0] mem [2**AW];
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];
    int checks = 0, errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_mem_engine #(.ADDR_W(AW), .WRITE_TICKS(WT)) uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si), .wp_n(wp_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
    assign mem_rdata = mem[mem_addr];

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
        rx = '0;
        oe = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            si = tx[i];
            tick(HP);
            rx[i] = so;
            oe = oe & so_oe;
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
    endtask

    task automatic tx8(input logic [7:0] b);
        logic [7:0] r;
        logic o;
        xfer(b, r, o);
    endtask

    task automatic cs_lo;
        cs_n = 1'b0;
        tick(HP);
    endtask

    task automatic cs_hi;
        tick(HP);
        cs_n = 1'b1;
        tick(2 * HP);
    endtask

    task automatic cmd(input logic [7:0] op);
        cs_lo; tx8(op); cs_hi;
    endtask

    task automatic rdsr(output logic [7:0] s, output logic oe);
        cs_lo; tx8(8'h05); xfer(8'h00, s, oe); cs_hi;
    endtask

    task automatic wait_idle;
        tick(WT + 50);
    endtask

    task automatic wr_array(input logic [15:0] a, input int n);
        cs_lo; tx8(8'h02); tx8(a[15:8]); tx8(a[7:0]);
        for (int k = 0; k < n; k++) tx8(wbuf[k]);
        cs_hi;
    endtask

    task automatic rd_array(input logic [15:0] a, input int n);
        logic o;
        cs_lo; tx8(8'h03); tx8(a[15:8]); tx8(a[7:0]);
        for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k], o);
        cs_hi;
    endtask

    task automatic wrsr(input logic [7:0] v);
        cmd(8'h06);
        cs_lo; tx8(8'h01); tx8(v); cs_hi;
        wait_idle;
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] d);
        cmd(8'h06);
        wbuf[0] = d;
        wr_array(a, 1);
        wait_idle;
    endtask

    task automatic t_reset;
        logic [7:0] s;
        logic o;
        chk("R1 so_oe after reset", so_oe, 1'b0);
        cs_lo; tx8(8'h05); xfer(8'h00, s, o);
        chk("R1 select held from reset ignored", o, 1'b0);
        cs_hi;
        chk("R2 so_oe low when deselected", so_oe, 1'b0);
        rdsr(s, o);
        chk("R1 status after reset", s, 8'h00);
        chk("R2 so_oe during status data", o, 1'b1);
    endtask

    task automatic t_flags;
        logic [7:0] s, s2;
        logic o;
        cmd(8'h00);
        rdsr(s, o);
        chk("R3 flag set", s, 8'h40);
        cmd(8'h06);
        cs_lo; tx8(8'h05); xfer(8'h00, s, o); xfer(8'h00, s2, o); cs_hi;
        chk("R4 status first byte", s, 8'h42);
        chk("R4 status repeated", s2, 8'h42);
        cmd(8'h04);
        rdsr(s, o);
        chk("R3 clear latch and flag", s, 8'h00);
    endtask

    task automatic t_chain;
        logic [7:0] s;
        logic o;
        cs_lo; tx8(8'h06); tx8(8'h02); tx8(8'h00); tx8(8'h44); tx8(8'h77); cs_hi;
        wait_idle;
        chk("R12 write after enable in same select", mem[11'h044], 8'hFF);
        rdsr(s, o);
        chk("R12 latch set, no busy", s, 8'h02);
        cmd(8'h04);
    endtask

    task automatic t_write_busy;
        logic [7:0] s;
        logic o;
        cmd(8'h06);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        wr_array(16'h0010, 3);
        cmd(8'h00);
        rdsr(s, o);
        chk("R11 busy readable, flag ignored", s, 8'h03);
        wait_idle;
        rdsr(s, o);
        chk("R11 latch cleared at end", s, 8'h00);
        rd_array(16'h0010, 3);
        chk("R5 read byte 0", rbuf[0], 8'hA1);
        chk("R5 read byte 1", rbuf[1], 8'hB2);
        chk("R5 read byte 2", rbuf[2], 8'hC3);
    endtask

    task automatic t_read_wrap;
        mem[11'h7FF] = 8'h5A;
        mem[11'h000] = 8'hA5;
        rd_array(16'h07FF, 3);
        chk("R5 top byte", rbuf[0], 8'h5A);
        chk("R5 wrap to zero", rbuf[1], 8'hA5);
        chk("R5 next after wrap", rbuf[2], 8'hFF);
    endtask

    task automatic t_abort;
        logic [7:0] s;
        logic o;
        cmd(8'h06);
        cs_lo; tx8(8'h02); tx8(8'h01); tx8(8'h00); tx8(8'h66);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; tick(HP); sck = 1'b1; tick(HP); sck = 1'b0;
        end
        cs_hi;
        rdsr(s, o);
        chk("R7 mid-byte abort no busy", s, 8'h02);
        chk("R7 mid-byte abort no write", mem[11'h100], 8'hFF);
        cs_lo; tx8(8'h02); tx8(8'h01); tx8(8'h01); cs_hi;
        rdsr(s, o);
        chk("R7 zero data bytes no busy", s, 8'h02);
        wait_idle;
        chk("R7 zero data bytes no write", mem[11'h101], 8'hFF);
    endtask

    task automatic t_no_wel;
        logic [7:0] s;
        logic o;
        cmd(8'h04);
        wbuf[0] = 8'h77;
        wr_array(16'h0200, 1);
        rdsr(s, o);
        chk("R6 write without latch no busy", s, 8'h00);
        wait_idle;
        chk("R6 write without latch no change", mem[11'h200], 8'hFF);
        cs_lo; tx8(8'h01); tx8(8'h0C); cs_hi;
        rdsr(s, o);
        chk("R6 status write without latch", s, 8'h00);
    endtask

    task automatic t_page_wrap;
        cmd(8'h06);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02; wbuf[2] = 8'h03; wbuf[3] = 8'h04;
        wr_array(16'h005E, 4);
        wait_idle;
        chk("R8 offset 30", mem[11'h05E], 8'h01);
        chk("R8 offset 31", mem[11'h05F], 8'h02);
        chk("R8 wrapped to page start", mem[11'h040], 8'h03);
        chk("R8 wrapped second", mem[11'h041], 8'h04);
        chk("R8 next page untouched", mem[11'h060], 8'hFF);
    endtask

    task automatic t_protect;
        wrsr(8'h04);
        write_one(16'h0600, 8'h11);
        chk("R9 quarter protects 0x600", mem[11'h600], 8'hFF);
        write_one(16'h05FF, 8'h22);
        chk("R9 quarter leaves 0x5FF", mem[11'h5FF], 8'h22);
        wrsr(8'h08);
        write_one(16'h0500, 8'h33);
        chk("R9 half protects 0x500", mem[11'h500], 8'hFF);
        write_one(16'h03FF, 8'h44);
        chk("R9 half leaves 0x3FF", mem[11'h3FF], 8'h44);
        wrsr(8'h0C);
        write_one(16'h0001, 8'h55);
        chk("R9 full protects 0x001", mem[11'h001], 8'hFF);
        wrsr(8'h00);
    endtask

    task automatic t_wp;
        logic [7:0] s;
        logic o;
        wrsr(8'h83);
        rdsr(s, o);
        chk("R10 low bits ignored", s, 8'h80);
        wp_n = 1'b0;
        wrsr(8'h0C);
        rdsr(s, o);
        chk("R10 refused with pin low", s, 8'h82);
        wp_n = 1'b1;
        wrsr(8'h88);
        rdsr(s, o);
        chk("R10 accepted with pin high", s, 8'h88);
        cmd(8'h06);
        cs_lo; tx8(8'h01); tx8(8'h80); cs_hi;
        wp_n = 1'b0;
        wait_idle;
        rdsr(s, o);
        chk("R10 started write completes", s, 8'h80);
        wp_n = 1'b1;
        wrsr(8'h00);
        rdsr(s, o);
        chk("R10 restore", s, 8'h00);
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) mem[i] = 8'hFF;
        rst = 1'b1; cs_n = 1'b0; sck = 1'b0; si = 1'b0; wp_n = 1'b1;
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset;
        t_flags;
        t_chain;
        t_write_busy;
        t_read_wrap;
        t_abort;
        t_no_wel;
        t_page_wrap;
        t_protect;
        t_wp;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule